// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Timing Modes

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks. Either clock may run at any rate up to the maximum, or stop, with no required ratio between them. A word is accepted on each write-clock rising edge while write enable is high and space remains. Words are delivered on the read side in the order they were written, through a registered data output.

A mode input is sampled while master reset is held, and it picks one of two timing modes. In standard mode the two status outputs act as an empty flag and a full flag, and each read request loads the next word into the output register. In fall-through mode the same two outputs act as an output-ready flag and an input-ready flag. In this mode the oldest word is moved onto the output by itself, so the output register adds one word of capacity. A half-full flag is driven in the write domain. Partial reset empties the buffer but keeps the mode. Retransmit returns the read side to the first word written since the last reset, after a fixed number of read-clock cycles.

Pointers cross between the domains in Gray code through two-flop synchronizers. Full and half-full are derived in the write domain, and empty in the read domain.

Top module: `dcfifo_dualmode`

## Requirements
- R1: Words written on write-clock edges with wr_en high and space available leave the read side in the same order, with no loss or duplication, under concurrent writing and reading.
- R2: Standard mode (fwft_sel low during master reset): rd_flag is 1 exactly when no word is stored. A read-clock edge with rd_en high and rd_flag low places the next word on rd_data just after that edge.
- R3: Standard mode: wr_flag is 1 once DEPTH words are stored. Occupancy never exceeds DEPTH.
- R4: Fall-through mode (fwft_sel high during master reset): the oldest word appears on rd_data with rd_flag 1 and no read request. rd_data and rd_flag hold until an edge with rd_en high consumes the word.
- R5: Fall-through mode: wr_flag is 1 while space remains. Total capacity is DEPTH+1 words (storage array plus output word).
- R6: A write while the FIFO is full is ignored. In standard mode, a read while it is empty is ignored, and rd_data keeps its value.
- R7: half_full is 1 when the storage array holds at least DEPTH/2 words, and 0 below that, once both domains have settled. In fall-through mode the word held on the output is not counted.
- R8: After a write into an empty FIFO, rd_flag falls within 4 read-clock cycles in standard mode and rises within 5 in fall-through mode.
- R9: Master reset empties the FIFO and resamples fwft_sel.
- R10: Partial reset empties the FIFO and ignores fwft_sel, keeping the current mode.
- R11: A one-cycle rt pulse moves the read side back to the first word written since the last reset. In standard mode rd_flag is 0 after the rt edge. In fall-through mode rd_flag is 0 after the rt edge, and that first word is presented with rd_flag 1 after the next edge.
- R12: After reset, rd_data is 0 and half_full is 0. Standard mode shows rd_flag 1 and wr_flag 0. Fall-through mode shows rd_flag 0 and wr_flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, sampled by both clocks |
| prst | input | 1 | Partial reset, active high, keeps the mode |
| fwft_sel | input | 1 | Mode select sampled during master reset: 0 standard, 1 fall-through |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rt | input | 1 | Retransmit request, read domain |
| rd_data | output | DATA_W | Registered read data |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| half_full | output | 1 | Storage holds at least DEPTH/2 words |

## Verification
The assertions assume the following about the inputs:
- Both resets are held for several cycles of both clocks while both clocks run.
- fwft_sel stays steady throughout a master reset.
- rt is pulsed only while the write side is idle and no more than DEPTH words have been written since the last reset. The read pointer then jumps in several Gray bits at once, and the write side must not be acting on it.

The stimulus keeps within these assumptions. It changes every input on falling clock edges and releases resets at points that never coincide with the other clock's rising edge. It issues retransmit only after a bounded fill followed by idle settling time.

// File: rtl/fdm_pkg.sv
package fdm_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fdm_mode_e;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fdm_sync2.sv
module fdm_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/fdm_mem.sv
module fdm_mem #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/fdm_wr_ctrl.sv
module fdm_wr_ctrl #(
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              fwft_sel,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rq2_gray,
    output logic              mem_we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              wr_flag,
    output logic              half_full
);
    import fdm_pkg::*;

    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [PW-1:0] wbin;
        logic [PW-1:0] wgray;
        fdm_mode_e     mode;
    } wst_t;

    wst_t          st_d, st_q;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] used;
    logic          full;
    logic [PW-1:0] wbin_inc;

    always_comb begin
        rbin_s   = PW'(gray2bin(32'(rq2_gray)));
        used     = st_q.wbin - rbin_s;
        full     = (used == PW'(DEPTH));
        mem_we   = wr_en && !full && !mrst && !prst;
        wbin_inc = st_q.wbin + PW'(1);

        st_d = st_q;
        if (mrst) begin
            st_d.wbin  = '0;
            st_d.wgray = '0;
            st_d.mode  = fwft_sel ? MODE_FWFT : MODE_STD;
        end else if (prst) begin
            st_d.wbin  = '0;
            st_d.wgray = '0;
        end else if (mem_we) begin
            st_d.wbin  = wbin_inc;
            st_d.wgray = PW'(bin2gray(32'(wbin_inc)));
        end
    end

    always_ff @(posedge wclk) begin
        st_q <= st_d;
    end

    assign waddr     = st_q.wbin[ADDR_W-1:0];
    assign wgray     = st_q.wgray;
    assign wr_flag   = (st_q.mode == MODE_FWFT) ? !full : full;
    assign half_full = (used >= PW'(DEPTH / 2));

    // R6
    wr_full_hold_chk: assert property (@(posedge wclk) disable iff (mrst || prst)
        (wr_en && full) |=> $stable(st_q.wbin));

    // R3
    occupancy_chk: assert property (@(posedge wclk) disable iff (mrst || prst)
        (used <= PW'(DEPTH)));

endmodule

// File: rtl/fdm_rd_ctrl.sv
module fdm_rd_ctrl #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              rclk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              fwft_sel,
    input  logic              rd_en,
    input  logic              rt,
    input  logic [ADDR_W:0]   wq2_gray,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag
);
    import fdm_pkg::*;

    localparam int PW = ADDR_W + 1;

    typedef struct packed {
        logic [PW-1:0]     rbin;
        logic [PW-1:0]     rgray;
        logic [DATA_W-1:0] dout;
        logic              ovalid;
        fdm_mode_e         mode;
    } rst_t;

    rst_t          st_d, st_q;
    logic          empty;
    logic          pop;
    logic [PW-1:0] rbin_inc;

    always_comb begin
        empty    = (st_q.rgray == wq2_gray);
        rbin_inc = st_q.rbin + PW'(1);
        pop      = 1'b0;

        st_d = st_q;
        if (mrst) begin
            st_d      = '0;
            st_d.mode = fwft_sel ? MODE_FWFT : MODE_STD;
        end else if (prst) begin
            st_d.rbin   = '0;
            st_d.rgray  = '0;
            st_d.dout   = '0;
            st_d.ovalid = 1'b0;
        end else if (rt) begin
            st_d.rbin   = '0;
            st_d.rgray  = '0;
            st_d.ovalid = 1'b0;
        end else if (st_q.mode == MODE_STD) begin
            pop = rd_en && !empty;
        end else begin
            if ((!st_q.ovalid || rd_en) && !empty) begin
                pop = 1'b1;
            end else if (rd_en) begin
                st_d.ovalid = 1'b0;
            end
        end

        if (pop) begin
            st_d.dout   = mem_rdata;
            st_d.rbin   = rbin_inc;
            st_d.rgray  = PW'(bin2gray(32'(rbin_inc)));
            st_d.ovalid = 1'b1;
        end
    end

    always_ff @(posedge rclk) begin
        st_q <= st_d;
    end

    assign raddr   = st_q.rbin[ADDR_W-1:0];
    assign rgray   = st_q.rgray;
    assign rd_data = st_q.dout;
    assign rd_flag = (st_q.mode == MODE_FWFT) ? st_q.ovalid : empty;

    // R6
    rd_empty_hold_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
        (st_q.mode == MODE_STD && rd_en && empty && !rt) |=> $stable(rd_data));

    // R4
    fwft_hold_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
        (st_q.mode == MODE_FWFT && st_q.ovalid && !rd_en && !rt) |=> (rd_flag && $stable(rd_data)));

    // R11
    retransmit_rewind_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
        rt |=> (st_q.rbin == '0 && !st_q.ovalid));

    // R10
    mode_keep_chk: assert property (@(posedge rclk) disable iff (mrst)
        prst |=> $stable(st_q.mode));

endmodule

// File: rtl/dcfifo_dualmode.sv
module dcfifo_dualmode #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              fwft_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rt,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag,
    output logic              wr_flag,
    output logic              half_full
);
    localparam int PW = ADDR_W + 1;

    logic              mem_we;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     wq2_gray;
    logic [PW-1:0]     rq2_gray;
    logic              clr_any;

    assign clr_any = mrst || prst;

    fdm_wr_ctrl #(.ADDR_W(ADDR_W)) wr_ctrl_i (
        .wclk      (wclk),
        .mrst      (mrst),
        .prst      (prst),
        .fwft_sel  (fwft_sel),
        .wr_en     (wr_en),
        .rq2_gray  (rq2_gray),
        .mem_we    (mem_we),
        .waddr     (waddr),
        .wgray     (wgray),
        .wr_flag   (wr_flag),
        .half_full (half_full)
    );

    fdm_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    fdm_sync2 #(.W(PW)) w2r_sync_i (
        .clk (rclk),
        .clr (clr_any),
        .d   (wgray),
        .q   (wq2_gray)
    );

    fdm_sync2 #(.W(PW)) r2w_sync_i (
        .clk (wclk),
        .clr (clr_any),
        .d   (rgray),
        .q   (rq2_gray)
    );

    fdm_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) rd_ctrl_i (
        .rclk      (rclk),
        .mrst      (mrst),
        .prst      (prst),
        .fwft_sel  (fwft_sel),
        .rd_en     (rd_en),
        .rt        (rt),
        .wq2_gray  (wq2_gray),
        .mem_rdata (mem_rdata),
        .raddr     (raddr),
        .rgray     (rgray),
        .rd_data   (rd_data),
        .rd_flag   (rd_flag)
    );
endmodule

// File: tb/dcfifo_dualmode_tb_top.sv
module dcfifo_dualmode_tb_top;
    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = CLK_PERIOD + 4;
    localparam int DW          = 18;
    localparam int AW          = 3;
    localparam int DEPTH       = 1 << AW;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          mrst = 1'b1;
    logic          prst = 1'b0;
    logic          fwft_sel = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic          rt = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_flag;
    logic          wr_flag;
    logic          half_full;

    int            checks = 0;
    int            errors = 0;
    bit            cur_fwft = 1'b0;
    bit            done = 1'b0;
    logic [DW-1:0] model_q[$];
    logic [DW-1:0] hist[$];

    always #(CLK_PERIOD / 2) wclk = ~wclk;
    always #(RCLK_PERIOD / 2) rclk = ~rclk;

    dcfifo_dualmode #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .wclk (wclk), .rclk (rclk), .mrst (mrst), .prst (prst),
        .fwft_sel (fwft_sel), .wr_en (wr_en), .wr_data (wr_data),
        .rd_en (rd_en), .rt (rt), .rd_data (rd_data), .rd_flag (rd_flag),
        .wr_flag (wr_flag), .half_full (half_full)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit space();
        return cur_fwft ? wr_flag : !wr_flag;
    endfunction

    function automatic bit ready();
        return cur_fwft ? rd_flag : !rd_flag;
    endfunction

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (3) @(negedge wclk);
    endtask

    task automatic apply_reset(bit master, bit sel);
        @(negedge wclk);
        if (master) mrst = 1'b1; else prst = 1'b1;
        fwft_sel = sel;
        wr_en = 1'b0; rd_en = 1'b0; rt = 1'b0;
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        mrst = 1'b0; prst = 1'b0;
        model_q.delete(); hist.delete();
        if (master) cur_fwft = sel;
        settle();
    endtask

    task automatic write_n(int n, int base);
        int i = 0;
        int guard = 0;
        while (i < n && guard < 2000) begin
            @(negedge wclk); guard++;
            if (space()) begin
                wr_en = 1'b1; wr_data = DW'(base + i);
                model_q.push_back(DW'(base + i)); hist.push_back(DW'(base + i));
                i++;
            end else begin
                wr_en = 1'b0;
            end
        end
        @(negedge wclk); wr_en = 1'b0;
        if (i < n) chk("R1 write timeout", i, n);
    endtask

    task automatic write_forced(int v);
        @(negedge wclk);
        wr_en = 1'b1; wr_data = DW'(v);
        if (space()) begin model_q.push_back(DW'(v)); hist.push_back(DW'(v)); end
        @(negedge wclk); wr_en = 1'b0;
    endtask

    task automatic read_n(int n, string req);
        int            got = 0;
        int            guard = 0;
        bit            pend = 1'b0;
        logic [DW-1:0] exp = '0;
        while (got < n && guard < 2000) begin
            @(negedge rclk); guard++;
            if (pend) begin chk(req, int'(rd_data), int'(exp)); pend = 1'b0; end
            rd_en = 1'b0;
            if (!cur_fwft) begin
                if (!rd_flag && model_q.size() > 0) begin
                    rd_en = 1'b1; exp = model_q.pop_front(); pend = 1'b1; got++;
                end
            end else if (rd_flag && model_q.size() > 0) begin
                chk(req, int'(rd_data), int'(model_q[0]));
                rd_en = 1'b1; void'(model_q.pop_front()); got++;
            end
        end
        @(negedge rclk);
        if (pend) chk(req, int'(rd_data), int'(exp));
        rd_en = 1'b0;
        if (got < n) chk({req, " read timeout"}, got, n);
    endtask

    task automatic latency(int v, int limit, string req);
        int n = 0;
        write_n(1, v);
        while (n < 20) begin
            @(negedge rclk); n++;
            if (ready()) break;
        end
        chk(req, (n <= limit) ? 1 : 0, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Standard mode after master reset
        apply_reset(1'b1, 1'b0);
        chk("R12 std rd_flag", int'(rd_flag), 1);
        chk("R12 std wr_flag", int'(wr_flag), 0);
        chk("R12 half_full", int'(half_full), 0);
        chk("R12 rd_data", int'(rd_data), 0);

        // R6 read while empty
        @(negedge rclk); rd_en = 1'b1;
        repeat (3) @(negedge rclk);
        rd_en = 1'b0;
        chk("R6 empty read data", int'(rd_data), 0);
        chk("R6 empty read flag", int'(rd_flag), 1);

        // R8 standard latency, R2 read
        latency(11, 4, "R8 std first word latency");
        read_n(1, "R2 std read");
        settle();
        chk("R2 empty again", int'(rd_flag), 1);

        // R7 half-full
        write_n(DEPTH / 2 - 1, 200);
        settle();
        chk("R7 below half", int'(half_full), 0);
        write_n(1, 300);
        settle();
        chk("R7 at half", int'(half_full), 1);
        read_n(DEPTH / 2, "R2 half drain");
        settle();
        chk("R7 drained", int'(half_full), 0);

        // R3 full, R6 ignored write
        write_n(DEPTH, 400);
        settle();
        chk("R3 full flag", int'(wr_flag), 1);
        write_forced(999);
        settle();
        read_n(DEPTH, "R6 full drain order");
        settle();
        chk("R6 ignored write left nothing", int'(rd_flag), 1);

        // R1 concurrent stream
        fork
            write_n(3 * DEPTH, 1000);
            read_n(3 * DEPTH, "R1 std stream");
        join
        settle();

        // R10 partial reset keeps standard mode
        apply_reset(1'b0, 1'b1);
        chk("R10 std kept rd_flag", int'(rd_flag), 1);
        chk("R10 std kept wr_flag", int'(wr_flag), 0);

        // R11 standard retransmit
        write_n(5, 2000);
        settle();
        read_n(5, "R2 pre retransmit");
        settle();
        @(negedge rclk); rt = 1'b1;
        @(negedge rclk); rt = 1'b0;
        chk("R11 std rd_flag after rt", int'(rd_flag), 0);
        model_q = hist;
        read_n(5, "R11 std replay");

        // R9 master reset into fall-through mode
        apply_reset(1'b1, 1'b1);
        chk("R9 fwft rd_flag", int'(rd_flag), 0);
        chk("R9 fwft wr_flag", int'(wr_flag), 1);
        chk("R12 fwft half_full", int'(half_full), 0);

        // R8 / R4 fall-through presentation
        latency(77, 5, "R8 fwft first word latency");
        chk("R4 word presented", int'(rd_data), 77);
        repeat (3) @(negedge rclk);
        chk("R4 held flag", int'(rd_flag), 1);
        chk("R4 held data", int'(rd_data), 77);
        read_n(1, "R4 consume");
        settle();
        chk("R4 after consume", int'(rd_flag), 0);

        // R5 capacity DEPTH+1
        write_n(DEPTH, 3000);
        settle();
        chk("R5 space after prefetch", int'(wr_flag), 1);
        chk("R7 fwft array count", int'(half_full), 1);
        write_n(1, 3100);
        settle();
        chk("R5 full at DEPTH+1", int'(wr_flag), 0);
        write_forced(888);
        settle();
        chk("R5 queue size", model_q.size(), DEPTH + 1);
        read_n(DEPTH + 1, "R5 drain order");
        settle();
        chk("R6 fwft ignored write", int'(rd_flag), 0);

        // R1 fall-through stream
        fork
            write_n(3 * DEPTH, 4000);
            read_n(3 * DEPTH, "R1 fwft stream");
        join
        settle();

        // R10 partial reset keeps fall-through mode
        apply_reset(1'b0, 1'b0);
        chk("R10 fwft kept rd_flag", int'(rd_flag), 0);
        chk("R10 fwft kept wr_flag", int'(wr_flag), 1);

        // R11 fall-through retransmit
        write_n(4, 5000);
        settle();
        read_n(4, "R4 pre retransmit");
        settle();
        @(negedge rclk); rt = 1'b1;
        @(negedge rclk); rt = 1'b0;
        chk("R11 fwft flag after rt edge", int'(rd_flag), 0);
        @(negedge rclk);
        chk("R11 fwft flag second edge", int'(rd_flag), 1);
        chk("R11 fwft first word", int'(rd_data), int'(hist[0]));
        model_q = hist;
        read_n(4, "R11 fwft replay");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule